// File: doc/BRIEF.md
# Alternating Two-Memory Frame Store

This block sits between a pixel source and a processing stage that needs the current frame and the frame before it at the same time. It takes one pixel stream and two external frame memories. During each frame one memory records the arriving pixels while the other plays back the frame recorded during the previous frame. At every frame boundary the two memories trade roles.

The block has two output streams. The live stream carries the arriving pixels. The previous-frame stream carries the pixel at the same position one frame earlier. Both streams change on the same clock cycle, so a consumer can pair them without any buffering of its own. Each memory is modelled as a plain synchronous port: one data word in, one data word out, an address, a write strobe and a read strobe. The read data arrives a fixed number of cycles after the read strobe.

The block assumes that all frames hold the same number of pixels. A frame boundary is marked by a one-cycle pulse. That pulse may come together with the first pixel of the new frame or on a cycle of its own.

Top module: `frame_pingpong_store`

## Requirements
- R1: While reset is active and on the first cycle after it, both write strobes, both read strobes, `live_valid` and `prev_valid` are low.
- R2: On a cycle with `pix_valid` high, exactly one memory has its write strobe high and the other memory has its read strobe high. On a cycle with `pix_valid` low, all four strobes are low.
- R3: Memory selection uses code 0 for memory A and code 1 for memory B. Pixels arriving before the first frame-start pulse go to memory B. Each `frame_start` pulse swaps the writing memory, taking effect on the pulse cycle itself. The first frame after reset is therefore written to memory A, and frames then alternate A, B, A, and so on.
- R4: The address is 0 for the first valid pixel of a frame and rises by one for each later valid pixel of that frame. Cycles without a valid pixel leave it unchanged. Both memories are given the same address.
- R5: The write data on both memory ports equals `pix_in` in the same cycle.
- R6: `live_pix` and `live_valid` repeat `pix_in` and `pix_valid` exactly `RD_LAT` cycles later.
- R7: When `prev_valid` is high, `prev_pix` equals the read data of the memory that was reading `RD_LAT` cycles earlier. That value is the pixel at the same position in the previous frame. When `prev_valid` is low, `prev_pix` is 0.
- R8: `prev_valid` stays low for every pixel of the first frame after reset. From the second frame onward it equals `live_valid`.
- R9: A `frame_start` pulse without a valid pixel still resets the address and swaps the roles. The next valid pixel is written at address 0 of the newly selected memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| pix_valid | input | 1 | Qualifies `pix_in` |
| pix_in | input | PIX_W | Incoming pixel |
| mem_a_addr | output | ADDR_W | Memory A address |
| mem_a_wdata | output | PIX_W | Memory A write data |
| mem_a_we | output | 1 | Memory A write strobe |
| mem_a_re | output | 1 | Memory A read strobe |
| mem_a_rdata | input | PIX_W | Memory A read data, `RD_LAT` cycles after the read strobe |
| mem_b_addr | output | ADDR_W | Memory B address |
| mem_b_wdata | output | PIX_W | Memory B write data |
| mem_b_we | output | 1 | Memory B write strobe |
| mem_b_re | output | 1 | Memory B read strobe |
| mem_b_rdata | input | PIX_W | Memory B read data, `RD_LAT` cycles after the read strobe |
| live_pix | output | PIX_W | Live pixel, aligned with `prev_pix` |
| live_valid | output | 1 | Live pixel valid |
| prev_pix | output | PIX_W | Pixel at the same position in the previous frame |
| prev_valid | output | 1 | Previous-frame pixel valid |

## Verification
The bench uses the default parameters: 8-bit pixels, a 32-bit address and a read latency of one cycle. Its two memory models answer one cycle after the read strobe. Frames are eight pixels long and include idle gaps. Four frames are enough to show the A/B alternation in both directions, playback from each memory and the first frame with no valid history. One frame boundary is a pulse without a pixel, so the address-reset path and the role-swap path can be seen apart from pixel traffic.

// File: rtl/fps_pkg.sv
// Shared definitions for the alternating frame store.
package fps_pkg;
    // Identifies one of the two frame memories.
    typedef enum logic {
        MEM_A = 1'b0,
        MEM_B = 1'b1
    } mem_sel_e;
endpackage

// File: rtl/fps_role_ctrl.sv
// Role and address control.
// Decides which memory records the current frame, produces the shared
// address, and records whether a full frame has already been stored.
// All outputs take effect in the same cycle as the frame_start pulse.
// Assumes frame_start is a one-cycle pulse.
module fps_role_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_valid,
    output mem_sel_e          wr_sel_now,
    output logic [ADDR_W-1:0] addr_now,
    output logic              history_now
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    mem_sel_e          wr_sel_q;
    logic [ADDR_W-1:0] cnt_q;
    logic              seen_start_q;
    logic              history_q;

    // Values for this cycle, with the frame_start pulse applied immediately.
    always_comb begin
        wr_sel_now  = frame_start ? mem_sel_e'(~wr_sel_q) : wr_sel_q;
        addr_now    = frame_start ? '0 : cnt_q;
        history_now = frame_start ? seen_start_q : history_q;
    end

    // State update: role, next address, frame-history flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel_q     <= MEM_B;
            cnt_q        <= '0;
            seen_start_q <= 1'b0;
            history_q    <= 1'b0;
        end else begin
            wr_sel_q  <= wr_sel_now;
            cnt_q     <= pix_valid ? addr_now + ADDR_ONE : addr_now;
            history_q <= history_now;
            if (frame_start) begin
                seen_start_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fps_delay_line.sv
// Fixed-length register delay line.
// Delays a bus by DEPTH cycles so that the live stream lines up with the
// memory read data. Clears to zero on reset. DEPTH must be at least 1.
module fps_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        // One pipeline stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[i] <= '0;
            end else if (i == 0) begin
                stage_q[i] <= d;
            end else begin
                stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/frame_pingpong_store.sv
// Alternating two-memory frame store.
// One memory records the arriving frame while the other plays back the
// previous one. The roles swap at each frame_start. The live stream is
// delayed by RD_LAT so that it lines up with the playback data.
// Assumes equal-size frames and memories with a fixed read latency RD_LAT.
module frame_pingpong_store
    import fps_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 32,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [ADDR_W-1:0] mem_a_addr,
    output logic [PIX_W-1:0]  mem_a_wdata,
    output logic              mem_a_we,
    output logic              mem_a_re,
    input  logic [PIX_W-1:0]  mem_a_rdata,
    output logic [ADDR_W-1:0] mem_b_addr,
    output logic [PIX_W-1:0]  mem_b_wdata,
    output logic              mem_b_we,
    output logic              mem_b_re,
    input  logic [PIX_W-1:0]  mem_b_rdata,
    output logic [PIX_W-1:0]  live_pix,
    output logic              live_valid,
    output logic [PIX_W-1:0]  prev_pix,
    output logic              prev_valid
);
    localparam int PIPE_W = PIX_W + 3;

    mem_sel_e          wr_sel_now;
    logic [ADDR_W-1:0] addr_now;
    logic              history_now;
    logic [PIPE_W-1:0] pipe_in;
    logic [PIPE_W-1:0] pipe_out;
    logic              rd_sel_d;

    fps_role_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .wr_sel_now  (wr_sel_now),
        .addr_now    (addr_now),
        .history_now (history_now)
    );

    // Memory port drive: the writer records the pixel, the other memory reads.
    always_comb begin
        mem_a_addr  = addr_now;
        mem_b_addr  = addr_now;
        mem_a_wdata = pix_in;
        mem_b_wdata = pix_in;
        mem_a_we    = pix_valid && (wr_sel_now == MEM_A);
        mem_b_we    = pix_valid && (wr_sel_now == MEM_B);
        mem_a_re    = pix_valid && (wr_sel_now == MEM_B);
        mem_b_re    = pix_valid && (wr_sel_now == MEM_A);
    end

    // Bundle of everything that must travel alongside the memory read.
    assign pipe_in = {pix_in, pix_valid, pix_valid && history_now, ~wr_sel_now};

    fps_delay_line #(.W(PIPE_W), .DEPTH(RD_LAT)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pipe_in),
        .q     (pipe_out)
    );

    // Output select: take the read data from the memory that was reading.
    always_comb begin
        live_pix   = pipe_out[PIPE_W-1:3];
        live_valid = pipe_out[2];
        prev_valid = pipe_out[1];
        rd_sel_d   = pipe_out[0];
        if (!prev_valid) begin
            prev_pix = '0;
        end else if (rd_sel_d == MEM_A) begin
            prev_pix = mem_a_rdata;
        end else begin
            prev_pix = mem_b_rdata;
        end
    end
endmodule

// File: rtl/frame_pingpong_store_chk.sv
// Property checker for the alternating frame store, bound to the top.
module frame_pingpong_store_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              pix_valid,
    input logic [ADDR_W-1:0] mem_a_addr,
    input logic [ADDR_W-1:0] mem_b_addr,
    input logic              mem_a_we,
    input logic              mem_a_re,
    input logic              mem_b_we,
    input logic              mem_b_re,
    input logic              live_valid,
    input logic              prev_valid
);
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ($countones({mem_a_we, mem_b_we}) == 1 && mem_a_re == mem_b_we && mem_b_re == mem_a_we)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> !(mem_a_we || mem_b_we || mem_a_re || mem_b_re)); // R2

    AST_SWAP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && pix_valid && frame_start) |-> (mem_a_we == $past(mem_b_we))); // R3

    AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pix_valid) |-> (mem_a_addr == '0)); // R4

    AST_ADDR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_a_addr == mem_b_addr); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pix_valid) && !frame_start) |-> (mem_a_addr == $past(mem_a_addr) + 1)); // R4

    AST_PREV_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        prev_valid |-> live_valid); // R8
endmodule

bind frame_pingpong_store frame_pingpong_store_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .mem_a_addr  (mem_a_addr),
    .mem_b_addr  (mem_b_addr),
    .mem_a_we    (mem_a_we),
    .mem_a_re    (mem_a_re),
    .mem_b_we    (mem_b_we),
    .mem_b_re    (mem_b_re),
    .live_valid  (live_valid),
    .prev_valid  (prev_valid)
);

// File: tb/tb_frame_pingpong_store.sv
`timescale 1ns/1ps
module tb_frame_pingpong_store;
    localparam int FRAME_LEN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_in = '0;
    logic [31:0] mem_a_addr, mem_b_addr;
    logic [7:0]  mem_a_wdata, mem_b_wdata, mem_a_rdata, mem_b_rdata;
    logic        mem_a_we, mem_a_re, mem_b_we, mem_b_re;
    logic [7:0]  live_pix, prev_pix;
    logic        live_valid, prev_valid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    frame_pingpong_store dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_in(pix_in),
        .mem_a_addr(mem_a_addr), .mem_a_wdata(mem_a_wdata), .mem_a_we(mem_a_we),
        .mem_a_re(mem_a_re), .mem_a_rdata(mem_a_rdata),
        .mem_b_addr(mem_b_addr), .mem_b_wdata(mem_b_wdata), .mem_b_we(mem_b_we),
        .mem_b_re(mem_b_re), .mem_b_rdata(mem_b_rdata),
        .live_pix(live_pix), .live_valid(live_valid),
        .prev_pix(prev_pix), .prev_valid(prev_valid)
    );

    // Synchronous memory models with one cycle of read latency.
    logic [7:0] ram_a [256];
    logic [7:0] ram_b [256];
    always_ff @(posedge clk) begin
        if (mem_a_we) ram_a[mem_a_addr[7:0]] <= mem_a_wdata;
        if (mem_a_re) mem_a_rdata <= ram_a[mem_a_addr[7:0]];
        if (mem_b_we) ram_b[mem_b_addr[7:0]] <= mem_b_wdata;
        if (mem_b_re) mem_b_rdata <= ram_b[mem_b_addr[7:0]];
    end

    function automatic logic [7:0] pat(int frame, int idx);
        return 8'(frame * 37 + idx * 5 + 11);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive, check memory side, clock, check outputs.
    task automatic step(logic fs, logic v, logic [7:0] p, logic wr_b,
                        int addr, logic hist, logic [7:0] exp_prev);
        @(negedge clk);
        frame_start = fs; pix_valid = v; pix_in = p;
        #1;
        chk("R2", "a_we", mem_a_we, v && !wr_b);
        chk("R2", "b_we", mem_b_we, v && wr_b);
        chk("R2", "a_re", mem_a_re, v && wr_b);
        chk("R2", "b_re", mem_b_re, v && !wr_b);
        if (v) begin
            chk("R4", "a_addr", mem_a_addr, addr);
            chk("R4", "b_addr", mem_b_addr, addr);
            chk("R5", "wdata", wr_b ? mem_b_wdata : mem_a_wdata, p);
        end
        @(posedge clk);
        #1;
        chk("R6", "live_valid", live_valid, v);
        if (v) chk("R6", "live_pix", live_pix, p);
        chk("R8", "prev_valid", prev_valid, v && hist);
        chk("R7", "prev_pix", prev_pix, (v && hist) ? exp_prev : 8'h00);
    endtask

    // One frame with idle gaps; lone_start puts the pulse on a cycle with no pixel.
    task automatic run_frame(int frame, logic wr_b, logic lone_start);
        logic hist = (frame > 0);
        if (lone_start) step(1'b1, 1'b0, 8'h00, wr_b, 0, hist, 8'h00); // R9
        for (int i = 0; i < FRAME_LEN; i++) begin
            step(!lone_start && i == 0, 1'b1, pat(frame, i), wr_b, i, hist,
                 hist ? pat(frame - 1, i) : 8'h00);
            if (i % 3 == 1) step(1'b0, 1'b0, 8'hEE, wr_b, i + 1, hist, 8'h00);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1", "a_we", mem_a_we, 1'b0);
        chk("R1", "b_we", mem_b_we, 1'b0);
        chk("R1", "live_valid", live_valid, 1'b0);
        chk("R1", "prev_valid", prev_valid, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "live_valid_after", live_valid, 1'b0);
        chk("R1", "prev_valid_after", prev_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        run_frame(0, 1'b0, 1'b0);   // R3 first frame into memory A
        run_frame(1, 1'b1, 1'b0);   // R3 second frame into memory B, R7 playback from A
        run_frame(2, 1'b0, 1'b0);   // R7 playback from B
        run_frame(3, 1'b1, 1'b1);   // R9 lone pulse
        step(1'b0, 1'b0, 8'h00, 1'b1, 0, 1'b1, 8'h00);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule